// File: doc/BRIEF.md
# I2C Master Block Transfer Engine

This block runs a single block-write or block-read transaction on a two-wire bus as the controller. A one-cycle start pulse begins the transaction and sets busy. The engine then takes its first byte from the transmit queue. That byte carries the 7-bit target address and the direction bit. For a write, the engine keeps taking bytes from the same queue until it has sent the one marked as final. For a read, it collects a programmed number of bytes and pushes each one into the receive queue. When the transaction is over, busy falls and a 3-bit completion code shows how it ended.

Both bus lines are open drain. The engine pulls SCL or SDA low through an output enable and reads the real line level back. Bit timing is built from four quarter periods per SCL period. A clock-enable divider sets the length of a quarter. It offers a standard rate and a fast rate, chosen at start. If the transmit queue runs dry in the middle of a write, the engine holds SCL low and raises an underrun flag until software adds more bytes. It does not end the transfer. The engine also watches for lost arbitration, and it stops on a timeout if SCL is held low by another device for too long.

Top module: `i2c_blk_xfer`

## Requirements
- R1: The first transmit-queue entry of every transaction goes on the bus as the address byte. Its bit 0 selects the direction: 1 means read and 0 means write.
- R2: In a write, the engine sends queue entries after the address until it has sent one whose last flag (`tx_last_i`) is 1. It then issues STOP and takes no further entry from the queue.
- R3: In a read, the engine pushes exactly `rd_count_i` bytes into the receive queue, MSB first. It ACKs every byte except the final one, which it NACKs before STOP.
- R4: When the engine needs a byte and the queue is empty, `underrun_o` is 1 and SCL is held low. No entry is taken until the queue has data again, and then the transfer resumes.
- R5: `status_o` gives one of these codes: 0 success, 1 arbitration lost, 2 address NACK, 3 data NACK, 4 timeout.
- R6: `busy_o` goes high on the cycle after `start_i` is accepted. It stays high through the whole transaction, including any underrun stall, and falls only when the transaction has ended.
- R7: A quarter SCL period lasts CLK_HZ/(4*rate) clock cycles. The rate is FAST_HZ when `fast_i` was 1 at start, otherwise SLOW_HZ. An unstretched SCL period is therefore four quarters long.
- R8: If the engine leaves SDA released during an address or data bit but samples it low, it ends with code 1. It releases both lines at once, without a STOP.
- R9: If SCL is released by the engine but read low for TMO_CYC consecutive cycles, the engine ends with code 4 and releases both lines.
- R10: A NACK from the target ends the transfer with STOP. Any queue entries not yet taken stay in the queue.
- R11: While idle, and after reset, both enables are 0, busy is 0 and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a transaction when idle |
| fast_i | input | 1 | Rate select sampled at start: 1 fast, 0 standard |
| rd_count_i | input | CNT_W | Number of bytes to read, sampled at start |
| busy_o | output | 1 | Transaction in progress |
| status_o | output | 3 | Completion code of the last transaction |
| tx_empty_i | input | 1 | Transmit queue has no entry |
| tx_data_i | input | 8 | Byte at the head of the transmit queue |
| tx_last_i | input | 1 | Head entry is the final byte of a write |
| tx_pop_o | output | 1 | Takes the head entry this cycle |
| underrun_o | output | 1 | Engine is stalled waiting for a transmit entry |
| rx_push_o | output | 1 | Pushes `rx_data_o` into the receive queue |
| rx_data_o | output | 8 | Received byte |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Write lengths of one, three and four bytes, and read lengths of one, two and five bytes, run at both rates. Every byte value and every ACK/NACK decision is checked against arithmetic patterns, and the measured SCL period is compared with the divider formula for each rate. An entry placed behind the last-flagged byte shows whether the write really stops on the flag and not on an empty queue. A queue left empty in the middle of a write separates stalling from ending. NACKs placed on the address and on a middle data byte separate code 2 from code 3 and show how many entries are left. A line pulled low during a released address bit, and SCL held low from the start, exercise codes 1 and 4.

// File: rtl/i2c_bx_pkg.sv
package i2c_bx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOAD,
    ST_SEND,
    ST_RECV,
    ST_STOP
  } bx_state_e;

  localparam logic [2:0] CODE_OK        = 3'd0;
  localparam logic [2:0] CODE_ARB       = 3'd1;
  localparam logic [2:0] CODE_NACK_ADDR = 3'd2;
  localparam logic [2:0] CODE_NACK_DATA = 3'd3;
  localparam logic [2:0] CODE_TMO       = 3'd4;

  // clock cycles in one quarter of an SCL period, never below one
  function automatic int unsigned quarter_cycles(int unsigned clk_hz, int unsigned scl_hz);
    int unsigned q;
    q = clk_hz / (4 * scl_hz);
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/i2c_bx_tick.sv
module i2c_bx_tick #(
  parameter int unsigned SLOW_Q = 125,
  parameter int unsigned FAST_Q = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fast,
  output logic tick
);
  localparam int unsigned MAXQ = (SLOW_Q > FAST_Q) ? SLOW_Q : FAST_Q;
  localparam int CW = (MAXQ > 1) ? $clog2(MAXQ) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = fast ? CW'(FAST_Q - 1) : CW'(SLOW_Q - 1);
  assign tick = !clr && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2c_bx_tmo.sv
module i2c_bx_tmo #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = arm && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!arm)    cnt <= '0;
    else if (!expire) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2c_blk_xfer.sv
module i2c_blk_xfer
  import i2c_bx_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned SLOW_HZ = 100_000,
  parameter int unsigned FAST_HZ = 400_000,
  parameter int unsigned TMO_CYC = 1_000_000,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fast_i,
  input  logic [CNT_W-1:0] rd_count_i,
  output logic             busy_o,
  output logic [2:0]       status_o,
  input  logic             tx_empty_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_last_i,
  output logic             tx_pop_o,
  output logic             underrun_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             scl_i,
  input  logic             sda_i
);
  localparam int unsigned Q_SLOW = quarter_cycles(CLK_HZ, SLOW_HZ);
  localparam int unsigned Q_FAST = quarter_cycles(CLK_HZ, FAST_HZ);

  bx_state_e        st;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       shreg;
  logic             is_addr, rd_mode, last_flag, nack_r, fast_r, busy_r;
  logic [2:0]       code_r;
  logic [CNT_W-1:0] rx_left;
  logic             push_r;
  logic [7:0]       push_d;
  logic             scl_drv, sda_drv, sda_q;
  logic             tick, adv, sample, slot_end;

  // named internal events, observed by the bound checker
  logic ev_lost_arb, ev_timeout, ev_done;

  i2c_bx_tick #(.SLOW_Q(Q_SLOW), .FAST_Q(Q_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .clr(st == ST_IDLE || st == ST_LOAD),
    .fast(fast_r), .tick(tick)
  );

  i2c_bx_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .arm(busy_r && !scl_drv && !scl_i),
    .expire(ev_timeout)
  );

  // line drive per state and quarter; 1 = pull low
  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    case (st)
      ST_START: begin scl_drv = (q == 2'd3); sda_drv = q[1]; end
      ST_LOAD:  scl_drv = 1'b1;
      ST_SEND:  begin scl_drv = (q == 2'd0); sda_drv = (bitn != 4'd8) && !shreg[7]; end
      ST_RECV:  begin scl_drv = (q == 2'd0); sda_drv = (bitn == 4'd8) && (rx_left != CNT_W'(1)); end
      ST_STOP:  begin scl_drv = (q == 2'd0); sda_drv = !q[1]; end
      default:  ;
    endcase
  end

  // a quarter ends on a tick, but not while a released SCL still reads low
  assign adv         = tick && (scl_drv || scl_i);
  assign sample      = adv && (q == 2'd2);
  assign slot_end    = adv && (q == 2'd3);
  assign ev_lost_arb = (st == ST_SEND) && sample && (bitn != 4'd8) && shreg[7] && !sda_i;
  assign ev_done     = (st == ST_STOP) && slot_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; shreg <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; last_flag <= 1'b0; nack_r <= 1'b0;
      fast_r <= 1'b0; busy_r <= 1'b0; code_r <= CODE_OK; rx_left <= '0;
      push_r <= 1'b0; push_d <= '0; sda_q <= 1'b0;
    end else begin
      push_r <= 1'b0;
      sda_q  <= sda_drv;
      if (ev_timeout) begin
        st <= ST_IDLE; busy_r <= 1'b0; code_r <= CODE_TMO;
      end else begin
        case (st)
          ST_IDLE: if (start_i) begin
            st <= ST_START; q <= '0; busy_r <= 1'b1; code_r <= CODE_OK;
            rx_left <= rd_count_i; fast_r <= fast_i; is_addr <= 1'b1; rd_mode <= 1'b0;
          end
          ST_START: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd3) st <= ST_LOAD;
          end
          ST_LOAD: if (!tx_empty_i) begin
            shreg <= tx_data_i; last_flag <= tx_last_i;
            if (is_addr) rd_mode <= tx_data_i[0];
            st <= ST_SEND; q <= '0; bitn <= '0;
          end
          ST_SEND: if (ev_lost_arb) begin
            st <= ST_IDLE; busy_r <= 1'b0; code_r <= CODE_ARB;
          end else if (adv) begin
            q <= q + 2'd1;
            if (sample && bitn == 4'd8) nack_r <= sda_i;
            if (slot_end) begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1; shreg <= {shreg[6:0], 1'b0};
              end else begin
                bitn <= '0; is_addr <= 1'b0;
                if (nack_r) begin
                  code_r <= is_addr ? CODE_NACK_ADDR : CODE_NACK_DATA; st <= ST_STOP;
                end else if (is_addr && rd_mode) begin
                  st <= (rx_left == '0) ? ST_STOP : ST_RECV;
                end else begin
                  st <= last_flag ? ST_STOP : ST_LOAD;
                end
              end
            end
          end
          ST_RECV: if (adv) begin
            q <= q + 2'd1;
            if (sample && bitn != 4'd8) shreg <= {shreg[6:0], sda_i};
            if (slot_end) begin
              if (bitn == 4'd7) begin push_r <= 1'b1; push_d <= shreg; end
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0; rx_left <= rx_left - CNT_W'(1);
                if (rx_left == CNT_W'(1)) st <= ST_STOP;
              end
            end
          end
          ST_STOP: if (adv) begin
            q <= q + 2'd1;
            if (q == 2'd3) begin st <= ST_IDLE; busy_r <= 1'b0; end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = busy_r;
  assign status_o   = code_r;
  assign tx_pop_o   = (st == ST_LOAD) && !tx_empty_i;
  assign underrun_o = (st == ST_LOAD) && tx_empty_i;
  assign rx_push_o  = push_r;
  assign rx_data_o  = push_d;
  assign scl_oe_o   = scl_drv;
  // SDA moves one clock after SCL so a data change never meets a high SCL
  assign sda_oe_o   = sda_q;
endmodule

// File: rtl/i2c_bx_checker.sv
module i2c_bx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic [2:0] status_o,
  input logic       tx_pop_o,
  input logic       tx_empty_i,
  input logic       underrun_o,
  input logic       rx_push_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       ev_lost_arb,
  input logic       ev_timeout,
  input logic       ev_done
);
  a_r1_pop_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> busy_o && !tx_empty_i);

  a_r3_push_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> busy_o);

  a_r4_stall_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> scl_oe_o && busy_o && !tx_pop_o);

  a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> status_o <= 3'd4);

  a_r6_busy_ends_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(ev_done || ev_lost_arb || ev_timeout));

  a_r8_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lost_arb |=> !busy_o && !scl_oe_o && !sda_oe_o && status_o == 3'd1);

  a_r9_timeout_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> !busy_o && !scl_oe_o && status_o == 3'd4);

  a_r11_idle_scl_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scl_oe_o);

  a_r11_idle_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && $past(!busy_o) |-> !sda_oe_o);
endmodule

bind i2c_blk_xfer i2c_bx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .status_o(status_o),
  .tx_pop_o(tx_pop_o), .tx_empty_i(tx_empty_i), .underrun_o(underrun_o),
  .rx_push_o(rx_push_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .ev_lost_arb(ev_lost_arb), .ev_timeout(ev_timeout), .ev_done(ev_done)
);

// File: tb/i2c_blk_xfer_tb.sv
module i2c_blk_xfer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8_000_000;
  localparam int TMO        = 300;
  localparam int QS         = CLK_HZ / (4 * 100_000);
  localparam int QF         = CLK_HZ / (4 * 400_000);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fast = 1'b0;
  logic [7:0] rd_count = '0;
  logic busy, tx_pop, underrun, rx_push, scl_oe, sda_oe;
  logic [2:0] status;
  logic [7:0] rx_data;
  logic scl_hold = 1'b0, sda_pull = 1'b0, arb_pull = 1'b0;
  logic scl, sda;
  assign scl = !(scl_oe || scl_hold);
  assign sda = !(sda_oe || sda_pull || arb_pull);

  // transmit queue model
  logic [8:0] txm [0:63];
  int hd = 0, tl = 0;
  logic tx_empty;
  logic [8:0] tx_head;
  assign tx_empty = (hd == tl);
  assign tx_head  = txm[hd % 64];

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] rxg [0:63];
  int rxn = 0;

  i2c_blk_xfer #(.CLK_HZ(CLK_HZ), .TMO_CYC(TMO), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fast_i(fast), .rd_count_i(rd_count),
    .busy_o(busy), .status_o(status), .tx_empty_i(tx_empty), .tx_data_i(tx_head[7:0]),
    .tx_last_i(tx_head[8]), .tx_pop_o(tx_pop), .underrun_o(underrun),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .scl_i(scl), .sda_i(sda)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (tx_pop) hd <= hd + 1;
  always @(posedge clk) if (rx_push) begin rxg[rxn % 64] <= rx_data; rxn <= rxn + 1; end

  function automatic logic [7:0] rd_val(int j);
    return 8'(8'h5C + j * 39);
  endfunction
  function automatic logic [7:0] wr_val(int j);
    return 8'(8'hC3 ^ (j * 29));
  endfunction

  // SCL rise times for the period check
  int rise_n = 0;
  int rise_t [0:3];
  always @(posedge scl) begin
    if (rise_n < 4) rise_t[rise_n] = cyc;
    rise_n = rise_n + 1;
  end

  // target model
  logic ack_addr = 1'b1;
  int nack_at = 1000;
  logic m_act = 1'b0, m_first = 1'b0, m_addrph = 1'b0, m_rd = 1'b0, m_lastnack = 1'b0;
  int m_bc = 0, m_byte = 0, m_wn = 0, m_mack = 0, m_mnack = 0, m_stops = 0;
  logic [7:0] m_shin = '0, m_cur = '0, m_addr = '0;
  logic [7:0] wrg [0:63];

  always @(negedge sda) if (scl) begin
    m_act = 1'b1; m_first = 1'b1; m_bc = 0; m_addrph = 1'b1; m_rd = 1'b0;
    m_byte = 0; m_wn = 0; m_mack = 0; m_mnack = 0; m_lastnack = 1'b0;
  end
  always @(posedge sda) if (scl && m_act) begin
    m_act = 1'b0; m_stops = m_stops + 1; sda_pull = 1'b0;
  end
  always @(posedge scl) if (m_act) begin
    if (m_bc < 8) begin
      if (m_addrph || !m_rd) m_shin = {m_shin[6:0], sda};
    end else if (!m_addrph && m_rd) begin
      m_lastnack = sda;
      if (sda) m_mnack = m_mnack + 1; else m_mack = m_mack + 1;
    end
  end
  always @(negedge scl) if (m_act) begin
    if (m_first) begin
      m_first = 1'b0; m_bc = 0; sda_pull = 1'b0;
    end else begin
      m_bc = m_bc + 1;
      if (m_bc == 8) begin
        if (m_addrph) begin m_addr = m_shin; m_rd = m_shin[0]; sda_pull = ack_addr; end
        else if (!m_rd) begin wrg[m_wn % 64] = m_shin; sda_pull = (m_wn < nack_at); m_wn = m_wn + 1; end
        else sda_pull = 1'b0;
      end else if (m_bc == 9) begin
        m_bc = 0;
        if (m_addrph) begin
          m_addrph = 1'b0;
          if (m_rd && ack_addr) begin m_cur = rd_val(0); sda_pull = !m_cur[7]; end
          else sda_pull = 1'b0;
        end else if (m_rd && !m_lastnack) begin
          m_byte = m_byte + 1; m_cur = rd_val(m_byte); sda_pull = !m_cur[7];
        end else sda_pull = 1'b0;
      end else if (!m_addrph && m_rd) begin
        sda_pull = !m_cur[7 - m_bc];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, logic last);
    txm[tl % 64] = {last, b};
    tl = tl + 1;
  endtask

  task automatic kick(logic f, int rc);
    @(negedge clk);
    fast = f; rd_count = 8'(rc); start = 1'b1; rise_n = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(int lim, output int took);
    took = 0;
    while (busy && took < lim) begin @(negedge clk); took = took + 1; end
    if (busy) begin
      n_fail = n_fail + 1; n_chk = n_chk + 1;
      $display("FAIL R6: busy still high after %0d cycles (expected low)", lim);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(logic f, int n, logic aack, int nat);
    int took, s0;
    @(negedge clk);
    tl = hd; ack_addr = aack; nack_at = nat; s0 = m_stops;
    push(8'hA4, 1'b0);
    for (int i = 0; i < n; i++) push(wr_val(i), i == n - 1);
    push(8'hEE, 1'b1);  // guard entry behind the last byte
    kick(f, 0);
    wait_idle(40000, took);
    chk("R1 address byte", int'(m_addr), 'hA4);
    chk("R10 stop issued", m_stops - s0, 1);
    if (!aack) begin
      chk("R5 code address NACK", int'(status), 2);
      chk("R10 entries left after address NACK", tl - hd, n + 1);
      chk("R10 no data bytes sent", m_wn, 0);
    end else if (nat < n) begin
      chk("R5 code data NACK", int'(status), 3);
      chk("R10 data bytes sent before NACK", m_wn, nat + 1);
      chk("R10 entries left after data NACK", tl - hd, n - nat);
    end else begin
      chk("R5 code success", int'(status), 0);
      chk("R2 data bytes sent", m_wn, n);
      chk("R2 guard entry untouched", tl - hd, 1);
      for (int i = 0; i < n; i++) chk("R2 data byte value", int'(wrg[i]), int'(wr_val(i)));
      chk("R7 SCL period", rise_t[1] - rise_t[0], 4 * (f ? QF : QS));
    end
  endtask

  task automatic do_read(logic f, int n, logic aack);
    int took, base;
    @(negedge clk);
    tl = hd; ack_addr = aack; nack_at = 1000; base = rxn;
    push(8'h3B, 1'b0);
    kick(f, n);
    wait_idle(40000, took);
    chk("R1 read address byte", int'(m_addr), 'h3B);
    if (!aack) begin
      chk("R5 code address NACK on read", int'(status), 2);
      chk("R3 nothing received", rxn - base, 0);
    end else begin
      chk("R5 code success read", int'(status), 0);
      chk("R3 byte count", rxn - base, n);
      for (int i = 0; i < n; i++) chk("R3 byte value", int'(rxg[(base + i) % 64]), int'(rd_val(i)));
      chk("R3 ACKs from engine", m_mack, n - 1);
      chk("R3 final NACK", m_mnack, 1);
      chk("R7 SCL period read", rise_t[1] - rise_t[0], 4 * (f ? QF : QS));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int took, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 status after reset", int'(status), 0);
    chk("R11 SCL released", int'(scl_oe), 0);
    chk("R11 SDA released", int'(sda_oe), 0);

    do_write(1'b0, 1, 1'b1, 1000);
    do_write(1'b0, 3, 1'b1, 1000);
    do_write(1'b1, 4, 1'b1, 1000);
    do_read(1'b0, 1, 1'b1);
    do_read(1'b1, 2, 1'b1);
    do_read(1'b0, 5, 1'b1);
    do_write(1'b1, 2, 1'b0, 1000);
    do_write(1'b0, 4, 1'b1, 1);
    do_read(1'b1, 3, 1'b0);

    // R4 underrun stall and resume
    @(negedge clk);
    tl = hd; ack_addr = 1'b1; nack_at = 1000;
    push(8'hA4, 1'b0); push(wr_val(0), 1'b0); push(wr_val(1), 1'b0);
    kick(1'b1, 0);
    took = 0;
    while (!underrun && took < 5000) begin @(negedge clk); took = took + 1; end
    chk("R4 underrun raised", int'(underrun), 1);
    repeat (50) @(negedge clk);
    chk("R4 still stalled", int'(underrun), 1);
    chk("R4 SCL held low in stall", int'(scl), 0);
    chk("R6 busy during stall", int'(busy), 1);
    push(wr_val(2), 1'b0); push(wr_val(3), 1'b1);
    wait_idle(40000, took);
    chk("R4 resumed to success", int'(status), 0);
    chk("R4 all bytes sent", m_wn, 4);
    for (int i = 0; i < 4; i++) chk("R4 byte value", int'(wrg[i]), int'(wr_val(i)));

    // R8 arbitration loss on the first address bit (address MSB is 1)
    @(negedge clk);
    tl = hd; push(8'hA4, 1'b0); push(wr_val(0), 1'b1);
    kick(1'b0, 0);
    took = 0;
    while (scl && took < 2000) begin @(negedge clk); took = took + 1; end
    @(negedge clk);
    arb_pull = 1'b1;
    wait_idle(5000, took);
    chk("R8 code lost arbitration", int'(status), 1);
    chk("R8 SCL released", int'(scl_oe), 0);
    chk("R8 SDA released", int'(sda_oe), 0);
    chk("R8 data entry untouched", tl - hd, 1);
    arb_pull = 1'b0;
    repeat (5) @(negedge clk);

    // R9 timeout with SCL held low by another device
    tl = hd; push(8'hA4, 1'b0); push(wr_val(0), 1'b1);
    scl_hold = 1'b1;
    @(negedge clk);
    t0 = cyc;
    kick(1'b0, 0);
    took = 0;
    while (busy && took < 5000) begin @(negedge clk); took = took + 1; end
    chk("R9 code timeout", int'(status), 4);
    chk("R9 timeout window", ((cyc - t0) >= TMO && (cyc - t0) <= TMO + 4) ? 1 : 0, 1);
    chk("R9 SCL released", int'(scl_oe), 0);
    @(negedge clk);
    chk("R9 SDA released", int'(sda_oe), 0);
    scl_hold = 1'b0;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule